// File: doc/BRIEF.md
# Stack and Fetch Bus Sequencer

This block turns stack, instruction-fetch and plain word-access requests from a CPU core into single-byte cycles on an 8-bit memory bus. It owns the 16-bit stack pointer and program counter. A request is taken in one cycle. The block then runs one byte cycle for a byte operation and two for a word operation. Each byte cycle waits on a ready handshake. At the end the block updates the stack pointer or program counter and returns any data it read.

Words are stored with the most significant byte at the lower address, and that byte is always transferred first. The stack grows downward, and the stack pointer names the next free byte. A push writes at or just below that pointer. A pop reads just above it. If the bus flags a fault, the operation stops at once and reports the failing address. The stack pointer and program counter then keep their old values.

Top module: `stk_fetch_seq`

## Requirements
- R1: After reset `sp` equals parameter SP_RESET, `pc` equals PC_RESET, and `busy`, `done`, `errValid` and `busReq` are low.
- R2: In every word operation the first byte cycle addresses the lower location and carries bits 15:8 of the value. The second cycle addresses the next location and carries bits 7:0.
- R3: Byte push (opCode 0) writes `opData[7:0]` at `sp`, then `sp` becomes `sp-1`.
- R4: Word push (opCode 1) writes `opData` at `sp-1` and `sp`, then `sp` becomes `sp-2`.
- R5: Byte pop (opCode 2) reads `sp+1`, returns `{8'h00,byte}` on `rdData` and sets `sp` to `sp+1`. Word pop (opCode 3) reads `sp+1` and `sp+2` and sets `sp` to `sp+2`.
- R6: Byte fetch (opCode 4) reads at `pc` and advances `pc` by 1. Word fetch (opCode 5) reads `pc` and `pc+1` and advances `pc` by 2. In both cases the data appears on `rdData`.
- R7: Word read (opCode 6) and word write (opCode 7) access `opAddr` and `opAddr+1`, and leave `sp` and `pc` unchanged.
- R8: Each byte cycle holds `busReq`, `busAddr`, `busWe` and `busWdata` steady until the cycle where `busRdy` is high.
- R9: If `busErr` is high together with `busRdy`, the operation ends. `done` and `errValid` pulse together, and `errAddr` gives that cycle's address. No further byte cycle starts, and `sp` and `pc` are unchanged.
- R10: All address and pointer arithmetic wraps modulo 2^16.
- R11: `busy` is high from the cycle after a request is accepted until the final ready. `done` is a one-cycle pulse in the next cycle, with `busy` low. `sp` and `pc` change only in that `done` cycle, and only without error.
- R12: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request strobe, taken when idle |
| opCode | input | 3 | Operation kind, 0 to 7 |
| opAddr | input | 16 | Address for word read/write |
| opData | input | 16 | Value to push or write |
| busReq | output | 1 | Byte cycle in progress |
| busWe | output | 1 | Byte cycle is a write |
| busAddr | output | 16 | Byte address |
| busWdata | output | 8 | Byte to write |
| busRdata | input | 8 | Byte read back |
| busRdy | input | 1 | Byte cycle completes |
| busErr | input | 1 | Byte cycle failed, valid with busRdy |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Operation finished, one cycle |
| errValid | output | 1 | Operation ended in a fault, with done |
| errAddr | output | 16 | Address of the last faulting byte |
| rdData | output | 16 | Data of the last completed read |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |

## Verification
The assertions check four things on every cycle: the bus signals hold still while a byte cycle is waiting, `done` is a lone pulse with `busy` low, and an error never comes without `done`. They also check that `sp` and `pc` move only in an error-free completion cycle, and only by the step sizes the operations allow. Only the bench's scenarios can show which addresses are used, their order, the byte placement and the returned data. The same holds for wrap across zero, the fault address for a failure on either byte, and a request ignored while busy. For these the bench sweeps every operation against several wait-state counts and fault positions.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    OP_PUSH8   = 3'd0,
    OP_PUSH16  = 3'd1,
    OP_POP8    = 3'd2,
    OP_POP16   = 3'd3,
    OP_FETCH8  = 3'd4,
    OP_FETCH16 = 3'd5,
    OP_READ16  = 3'd6,
    OP_WRITE16 = 3'd7
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // latch a new request
    logic capture;   // byte cycle finished cleanly
    logic lastByte;  // current byte cycle is the final one
    logic commit;    // whole operation finished cleanly
    logic fail;      // byte cycle reported a fault
    logic phase;     // 0 = first byte, 1 = second byte
  } strobe_t;

  function automatic logic opIsWord(opKind_t k);
    return !(k == OP_PUSH8 || k == OP_POP8 || k == OP_FETCH8);
  endfunction

  function automatic logic opIsWrite(opKind_t k);
    return (k == OP_PUSH8 || k == OP_PUSH16 || k == OP_WRITE16);
  endfunction

endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    opValid,
  input  opKind_t opCode,
  input  logic    busRdy,
  input  logic    busErr,
  output strobe_t stb,
  output logic    busReq,
  output logic    busy,
  output logic    done,
  output logic    errPulse
);

  typedef enum logic {S_IDLE, S_XFER} state_t;

  state_t stateQ;
  logic   phaseQ;
  logic   wordQ;
  logic   doneQ;
  logic   errQ;
  logic   hit;

  always_comb begin
    busReq       = (stateQ == S_XFER);
    hit          = busReq && busRdy;
    stb.accept   = (stateQ == S_IDLE) && opValid;
    stb.fail     = hit && busErr;
    stb.capture  = hit && !busErr;
    stb.lastByte = phaseQ || !wordQ;
    stb.commit   = stb.capture && stb.lastByte;
    stb.phase    = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      phaseQ <= 1'b0;
      wordQ  <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      doneQ <= stb.commit || stb.fail;
      errQ  <= stb.fail;
      case (stateQ)
        S_IDLE: begin
          if (stb.accept) begin
            stateQ <= S_XFER;
            phaseQ <= 1'b0;
            wordQ  <= opIsWord(opCode);
          end
        end
        S_XFER: begin
          if (stb.fail || stb.commit) begin
            stateQ <= S_IDLE;
            phaseQ <= 1'b0;
          end else if (stb.capture) begin
            phaseQ <= 1'b1;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign busy     = (stateQ == S_XFER);
  assign done     = doneQ;
  assign errPulse = errQ;

endmodule

// File: rtl/sfs_dpath.sv
module sfs_dpath
  import sfs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = '0,
  parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  opKind_t             opCode,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [2*BYTE_W-1:0] opData,
  input  logic [BYTE_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busWe,
  output logic [BYTE_W-1:0]   busWdata,
  output logic [ADDR_W-1:0]   sp,
  output logic [ADDR_W-1:0]   pc,
  output logic [2*BYTE_W-1:0] rdData,
  output logic [ADDR_W-1:0]   errAddr
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  opKind_t           opQ;
  logic [ADDR_W-1:0] baseQ;
  logic [WORD_W-1:0] dataQ;
  logic [BYTE_W-1:0] hiByteQ;
  logic [ADDR_W-1:0] spQ;
  logic [ADDR_W-1:0] pcQ;
  logic [WORD_W-1:0] rdQ;
  logic [ADDR_W-1:0] errQ;

  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] spNext;
  logic [ADDR_W-1:0] pcNext;
  logic              opWord;

  // first byte address of a new request
  always_comb begin
    case (opCode)
      OP_PUSH8:               startAddr = spQ;
      OP_PUSH16:              startAddr = spQ - ONE;
      OP_POP8, OP_POP16:      startAddr = spQ + ONE;
      OP_FETCH8, OP_FETCH16:  startAddr = pcQ;
      default:                startAddr = opAddr;
    endcase
  end

  // pointer values applied on clean completion
  always_comb begin
    spNext = spQ;
    pcNext = pcQ;
    case (opQ)
      OP_PUSH8:   spNext = spQ - ONE;
      OP_PUSH16:  spNext = spQ - TWO;
      OP_POP8:    spNext = spQ + ONE;
      OP_POP16:   spNext = spQ + TWO;
      OP_FETCH8:  pcNext = pcQ + ONE;
      OP_FETCH16: pcNext = pcQ + TWO;
      default: ;
    endcase
  end

  assign opWord   = opIsWord(opQ);
  assign busAddr  = baseQ + ADDR_W'(stb.phase);
  assign busWe    = opIsWrite(opQ);
  assign busWdata = (opWord && !stb.phase) ? dataQ[WORD_W-1:BYTE_W]
                                           : dataQ[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opQ     <= OP_PUSH8;
      baseQ   <= '0;
      dataQ   <= '0;
      hiByteQ <= '0;
      spQ     <= SP_RESET;
      pcQ     <= PC_RESET;
      rdQ     <= '0;
      errQ    <= '0;
    end else begin
      if (stb.accept) begin
        opQ   <= opCode;
        baseQ <= startAddr;
        dataQ <= opData;
      end
      if (stb.capture && !stb.lastByte) begin
        hiByteQ <= busRdata;
      end
      if (stb.commit) begin
        spQ <= spNext;
        pcQ <= pcNext;
        if (!busWe) begin
          rdQ <= opWord ? {hiByteQ, busRdata} : {{BYTE_W{1'b0}}, busRdata};
        end
      end
      if (stb.fail) begin
        errQ <= busAddr;
      end
    end
  end

  assign sp      = spQ;
  assign pc      = pcQ;
  assign rdData  = rdQ;
  assign errAddr = errQ;

endmodule

// File: rtl/stk_fetch_seq.sv
module stk_fetch_seq
  import sfs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = ADDR_W'(16'h00FF),
  parameter logic [ADDR_W-1:0] PC_RESET = ADDR_W'(16'h8000)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [2*BYTE_W-1:0] opData,
  output logic                busReq,
  output logic                busWe,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   busRdata,
  input  logic                busRdy,
  input  logic                busErr,
  output logic                busy,
  output logic                done,
  output logic                errValid,
  output logic [ADDR_W-1:0]   errAddr,
  output logic [2*BYTE_W-1:0] rdData,
  output logic [ADDR_W-1:0]   sp,
  output logic [ADDR_W-1:0]   pc
);

  strobe_t stb;
  opKind_t opKind;

  assign opKind = opKind_t'(opCode);

  sfs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opCode   (opKind),
    .busRdy   (busRdy),
    .busErr   (busErr),
    .stb      (stb),
    .busReq   (busReq),
    .busy     (busy),
    .done     (done),
    .errPulse (errValid)
  );

  sfs_dpath #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .SP_RESET (SP_RESET),
    .PC_RESET (PC_RESET)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .opCode   (opKind),
    .opAddr   (opAddr),
    .opData   (opData),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .sp       (sp),
    .pc       (pc),
    .rdData   (rdData),
    .errAddr  (errAddr)
  );

endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busReq,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic              busRdy,
  input logic              busy,
  input logic              done,
  input logic              errValid,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && !busRdy |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errValid |-> done);

  // R11 / R9
  sp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> done && !errValid);

  // R11 / R9
  pc_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> done && !errValid);

  // R3 R4 R5 R10
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) + ONE) || (sp == $past(sp) + TWO) ||
                     (sp == $past(sp) - ONE) || (sp == $past(sp) - TWO));

  // R6 R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> (pc == $past(pc) + ONE) || (pc == $past(pc) + TWO));

  // R7
  one_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> $stable(sp));

endmodule

bind stk_fetch_seq sfs_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busReq   (busReq),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdy   (busRdy),
  .busy     (busy),
  .done     (done),
  .errValid (errValid),
  .sp       (sp),
  .pc       (pc)
);

// File: tb/stk_fetch_seq_tb.sv
`timescale 1ns/1ps
module stk_fetch_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] opAddr = 16'h0;
  logic [15:0] opData = 16'h0;
  logic        busReq, busWe, busy, done, errValid;
  logic [15:0] busAddr, errAddr, rdData, sp, pc;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata = 8'h00;
  logic        busRdy = 1'b0;
  logic        busErr = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [15:0] mSp = 16'h0001;
  logic [15:0] mPc = 16'hFFFE;
  logic [7:0]  mem [int];

  always #10 clk = ~clk;

  stk_fetch_seq #(.SP_RESET(16'h0001), .PC_RESET(16'hFFFE)) u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opAddr(opAddr), .opData(opData), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRdy(busRdy), .busErr(busErr), .busy(busy), .done(done),
    .errValid(errValid), .errAddr(errAddr), .rdData(rdData),
    .sp(sp), .pc(pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdMem(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic string tagOf(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic runOp(input int op, input logic [15:0] a, input logic [15:0] d,
                       input int waits, input int errByte, input bit poke);
    logic [15:0] a0, ea, expRd;
    logic [7:0]  eb;
    bit word, wr;
    int nb;
    string tg;
    tg = tagOf(op);
    case (op)
      0: a0 = mSp;
      1: a0 = mSp - 16'd1;
      2, 3: a0 = mSp + 16'd1;
      4, 5: a0 = mPc;
      default: a0 = a;
    endcase
    word = !(op == 0 || op == 2 || op == 4);
    wr = (op == 0 || op == 1 || op == 7);
    nb = word ? 2 : 1;
    expRd = word ? {rdMem(a0), rdMem(a0 + 16'd1)} : {8'h00, rdMem(a0)};
    @(negedge clk);
    opValid = 1'b1; opCode = 3'(op); opAddr = a; opData = d;
    @(negedge clk);
    opValid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
    for (int b = 0; b < nb; b++) begin
      ea = a0 + 16'(b);
      eb = (word && b == 0) ? d[15:8] : d[7:0];
      for (int w = 0; w <= waits; w++) begin
        if (poke && w == 0) begin opValid = 1'b1; opCode = 3'd2; end
        if (poke && w == 1) opValid = 1'b0;
        check(busReq && busAddr == ea, (b == 1) ? "R2 second byte address" : tg,
              32'(busAddr), 32'(ea));
        check(busWe == wr, "R8 write direction", 32'(busWe), 32'(wr));
        if (wr) check(busWdata == eb, word ? "R2 byte order" : tg, 32'(busWdata), 32'(eb));
        if (w < waits) @(negedge clk);
      end
      busRdy = 1'b1;
      busErr = (b == errByte);
      if (!wr) busRdata = rdMem(busAddr);
      else if (b != errByte) mem[int'(busAddr)] = busWdata;
      @(negedge clk);
      busRdy = 1'b0; busErr = 1'b0;
      if (b == errByte) break;
    end
    check(done == 1'b1 && busy == 1'b0, "R11 done pulse", {busy, done}, 32'd1);
    if (errByte >= 0 && errByte < nb) begin
      check(errValid == 1'b1, "R9 error flag", 32'(errValid), 32'd1);
      check(errAddr == a0 + 16'(errByte), "R9 fault address", 32'(errAddr), 32'(a0 + 16'(errByte)));
    end else begin
      check(errValid == 1'b0, "R9 no error flag", 32'(errValid), 32'd0);
      case (op)
        0: mSp = mSp - 16'd1;
        1: mSp = mSp - 16'd2;
        2: mSp = mSp + 16'd1;
        3: mSp = mSp + 16'd2;
        4: mPc = mPc + 16'd1;
        5: mPc = mPc + 16'd2;
        default: ;
      endcase
      if (!wr) check(rdData == expRd, tg, 32'(rdData), 32'(expRd));
    end
    check(sp == mSp, poke ? "R12 sp after ignored request" : tg, 32'(sp), 32'(mSp));
    check(pc == mPc, tg, 32'(pc), 32'(mPc));
    @(negedge clk);
    check(done == 1'b0 && busReq == 1'b0, "R11 done single cycle", {busReq, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sp == 16'h0001 && pc == 16'hFFFE, "R1 pointers", {sp, pc}, 32'h0001FFFE);
    check(!busy && !done && !errValid && !busReq, "R1 idle", {busy, done, errValid, busReq}, 32'd0);
    rst_n = 1'b1;
    // wrap of stack through zero and fetch past the top
    runOp(0, 16'h0, 16'h0011, 0, -1, 0);
    runOp(1, 16'h0, 16'hA1B2, 1, -1, 0);
    check(sp == 16'hFFFE, "R10 sp wrap", 32'(sp), 32'hFFFE);
    runOp(5, 16'h0, 16'h0, 0, -1, 0);
    check(pc == 16'h0000, "R10 pc wrap", 32'(pc), 32'h0000);
    runOp(3, 16'h0, 16'h0, 0, -1, 0);
    check(rdData == 16'hA1B2, "R5 pop returns pushed word", 32'(rdData), 32'hA1B2);
    runOp(7, 16'hFFFF, 16'hC3D4, 0, -1, 0);
    runOp(6, 16'hFFFF, 16'h0, 2, -1, 0);
    check(rdData == 16'hC3D4, "R10 word across top", 32'(rdData), 32'hC3D4);
    // request while busy must be dropped
    runOp(1, 16'h0, 16'h5566, 3, -1, 1);
    // sweep: every operation, wait counts, fault positions
    for (int wt = 0; wt < 3; wt++) begin
      for (int op = 0; op < 8; op++) begin
        for (int e = -1; e < 2; e++) begin
          if (e == 1 && (op == 0 || op == 2 || op == 4)) continue;
          runOp(op, 16'h1230 + 16'(op * 4), 16'h9000 + 16'(wt * 256 + op * 16 + e + 1), wt, e, 0);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule